// File: doc/BRIEF.md
# Byte SEC-DED Codec

This block protects one 8-bit data byte with a single-error-correcting, double-error-detecting Hamming code. The encoder turns a byte into a 13-bit codeword: twelve positions carry the data and four check bits interleaved, and a thirteenth bit carries the parity of the whole word. The decoder takes a 13-bit codeword, possibly damaged on its way through a memory or a link, and returns the byte together with two flags: one says that a single bit was wrong and has been repaired, the other says that the word is damaged beyond repair.

The encoder and decoder are independent paths that share nothing but the code layout, so one instance can sit on both the write and read side of a small storage array. Both paths are combinational. A parameter adds one output register stage behind each of them. With the default setting the results appear one clock after the inputs.

Top module: `secded_codec`

## Requirements
- R1: Codeword bit b holds position b+1 for b = 0..11. The check bits sit at positions 1, 2, 4 and 8. Data bit k (k = 0..7) sits at positions 3, 5, 6, 7, 9, 10, 11 and 12 respectively. Bit 12 is the overall parity bit.
- R2: The check bit at position 2^i (i = 0..3) is set so that the XOR over all positions 1..12 whose index has bit i set, the check bit included, is zero.
- R3: The overall parity bit is set so that the XOR of all 13 codeword bits is zero.
- R4: An undamaged codeword decodes to its embedded data byte, with both flags low.
- R5: A codeword with exactly one flipped bit among positions 1..12 decodes to the original byte, with the single flag high and the double flag low.
- R6: A codeword whose only flipped bit is the overall parity bit returns the embedded byte unchanged, with the single flag high and the double flag low.
- R7: A codeword with exactly two flipped bits raises the double flag, keeps the single flag low, and returns the data bits exactly as they stand in the received word, without correction.
- R8: A group-parity syndrome in the range 13..15 points at no position. It raises the double flag and returns the received data bits uncorrected, whatever the overall parity says.
- R9: With OUT_REG = 1, every output follows its inputs one clock later. While rst_n is sampled low at a rising edge, all outputs are cleared to zero.
- R10: The single and double flags are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_data_i | input | 8 | Byte to encode |
| enc_code_o | output | 13 | Codeword produced from enc_data_i |
| dec_code_i | input | 13 | Received codeword to decode |
| dec_data_o | output | 8 | Decoded (corrected where possible) byte |
| dec_single_o | output | 1 | One error found and handled |
| dec_double_o | output | 1 | Uncorrectable error found |

## Verification
All 256 bytes are encoded and fed back undamaged. This separates layout and check-bit faults from decoder faults. Every one of the 13 single-bit flips is applied to a spread of bytes, so a wrong syndrome bit or a misplaced data bit shows up as a wrong corrected byte. The overall-bit flip is tried alone, because a decoder that corrects through the syndrome only would miss it. All 78 double flips on several bytes check that damage is reported and never "repaired". Triple flips whose syndromes land on 13, 14 and 15 separate the out-of-range rule from a plain single-error decision. A latency probe and a reset in the middle of the run check the register stage.

// File: rtl/secded_pkg.sv
// Package: shared widths, layout helpers and the decode classification.
// Assumes an interleaved Hamming layout with check bits at power-of-two
// positions (1-based) and one overall parity bit above the last position.
package secded_pkg;

    localparam int DATA_W = 8;
    localparam int CHK_W  = 4;
    localparam int POS_W  = DATA_W + CHK_W;
    localparam int CODE_W = POS_W + 1;
    localparam int SYN_W  = CHK_W;

    // Decoder verdict for one received word
    typedef enum logic [1:0] {
        K_CLEAN = 2'd0,
        K_FIX   = 2'd1,
        K_PAR   = 2'd2,
        K_BAD   = 2'd3
    } err_kind_t;

    // 1-based codeword position of data bit k (k-th non power-of-two slot)
    function automatic int data_pos(input int k);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p <= POS_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == k) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // Positions (1..POS_W) covered by check group i
    function automatic logic [POS_W:1] cover_mask(input int i);
        logic [POS_W:1] m;
        for (int p = 1; p <= POS_W; p++) m[p] = ((p >> i) & 1) != 0;
        return m;
    endfunction

    // Raw data bits of a codeword, no correction applied
    function automatic logic [DATA_W-1:0] extract_data(input logic [CODE_W-1:0] c);
        logic [DATA_W-1:0] d;
        for (int k = 0; k < DATA_W; k++) d[k] = c[data_pos(k) - 1];
        return d;
    endfunction

endpackage

// File: rtl/secded_enc.sv
// Encoder: scatters the data byte into the non power-of-two positions,
// fills each check position for even group parity, then appends the
// overall parity bit. Purely combinational.
module secded_enc
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);

    logic [POS_W:1] dpos;    // data bits in place, zeros at check slots
    logic [POS_W:1] full;    // data plus check bits
    logic [CHK_W-1:0] chk;

    // Place each data bit at its codeword slot
    always_comb begin
        dpos = '0;
        for (int k = 0; k < DATA_W; k++) dpos[data_pos(k)] = data_i[k];
    end

    // One check bit per group; the check slot itself is zero in dpos
    for (genvar i = 0; i < CHK_W; i++) begin : g_chk
        assign chk[i] = ^(dpos & cover_mask(i));
    end

    // Insert the check bits into their power-of-two slots
    always_comb begin
        full = dpos;
        for (int i = 0; i < CHK_W; i++) full[1 << i] = chk[i];
    end

    // Assemble the output word with the overall parity on top
    assign code_o = {^full, full};

endmodule

// File: rtl/secded_syn.sv
// Syndrome unit: recomputes every group parity over positions 1..POS_W
// of a received word and checks the parity of all CODE_W bits.
// Purely combinational.
module secded_syn
    import secded_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [SYN_W-1:0]  syn_o,
    output logic              par_fail_o
);

    logic [POS_W:1] pos;

    // Re-index the low bits as 1-based positions
    assign pos = code_i[POS_W-1:0];

    for (genvar i = 0; i < SYN_W; i++) begin : g_syn
        assign syn_o[i] = ^(pos & cover_mask(i));
    end

    // Odd parity over the whole word means an odd number of flips
    assign par_fail_o = ^code_i;

endmodule

// File: rtl/secded_fix.sv
// Corrector: classifies the received word from its syndrome and overall
// parity, flips the indicated position when a single error is certain,
// and extracts the data byte. Assumes the syndrome came from secded_syn.
module secded_fix
    import secded_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic [SYN_W-1:0]  syn_i,
    input  logic              par_fail_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              double_o
);

    err_kind_t      kind;
    logic [POS_W:1] pos;
    logic [POS_W:1] flip;
    logic [POS_W:1] fixed;
    logic           syn_nz;
    logic           syn_in_range;

    assign pos          = code_i[POS_W-1:0];
    assign syn_nz       = |syn_i;
    assign syn_in_range = (int'(syn_i) <= POS_W);

    // Decide what kind of damage the word carries
    always_comb begin
        if (syn_nz && !syn_in_range)      kind = K_BAD;
        else if (syn_nz && par_fail_i)    kind = K_FIX;
        else if (syn_nz)                  kind = K_BAD;
        else if (par_fail_i)              kind = K_PAR;
        else                              kind = K_CLEAN;
    end

    // One-hot flip mask, active only for a correctable single error
    for (genvar p = 1; p <= POS_W; p++) begin : g_flip
        assign flip[p] = (kind == K_FIX) && (int'(syn_i) == p);
    end

    assign fixed = pos ^ flip;

    // Pull the data bits out of the (possibly repaired) positions
    for (genvar k = 0; k < DATA_W; k++) begin : g_data
        assign data_o[k] = fixed[data_pos(k)];
    end

    // Map the verdict onto the two flags
    always_comb begin
        single_o = (kind == K_FIX) || (kind == K_PAR);
        double_o = (kind == K_BAD);
    end

endmodule

// File: rtl/secded_codec.sv
// Top: encoder path and decoder path side by side, each optionally
// followed by one register stage (OUT_REG). Synchronous active-low reset
// clears the registered outputs. Assumes one word per clock on each path.
module secded_codec
    import secded_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        enc_data_i,
    output logic [12:0]       enc_code_o,
    input  logic [12:0]       dec_code_i,
    output logic [7:0]        dec_data_o,
    output logic              dec_single_o,
    output logic              dec_double_o
);

    logic [CODE_W-1:0] enc_code_c;
    logic [SYN_W-1:0]  syn_c;
    logic              par_fail_c;
    logic [DATA_W-1:0] dec_data_c;
    logic              single_c;
    logic              double_c;

    secded_enc u_enc (
        .data_i (enc_data_i),
        .code_o (enc_code_c)
    );

    secded_syn u_syn (
        .code_i     (dec_code_i),
        .syn_o      (syn_c),
        .par_fail_o (par_fail_c)
    );

    secded_fix u_fix (
        .code_i     (dec_code_i),
        .syn_i      (syn_c),
        .par_fail_i (par_fail_c),
        .data_o     (dec_data_c),
        .single_o   (single_c),
        .double_o   (double_c)
    );

    if (OUT_REG) begin : g_reg
        // Register both paths; reset clears every output
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                enc_code_o   <= '0;
                dec_data_o   <= '0;
                dec_single_o <= 1'b0;
                dec_double_o <= 1'b0;
            end else begin
                enc_code_o   <= enc_code_c;
                dec_data_o   <= dec_data_c;
                dec_single_o <= single_c;
                dec_double_o <= double_c;
            end
        end

        // R1: data lands in its slots one clock after it is presented
        p_enc_place_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (extract_data(enc_code_o) == $past(enc_data_i)));

        // R7/R8: an uncorrectable verdict leaves the received data bits alone
        p_bad_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && dec_double_o) |->
                (dec_data_o == extract_data($past(dec_code_i))));

        // R5: a single-error verdict changes at most one data bit
        p_fix_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && dec_single_o) |->
                ($countones(dec_data_o ^ extract_data($past(dec_code_i))) <= 1));

        // R10: the two flags exclude each other
        p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !(dec_single_o && dec_double_o));
    end else begin : g_comb
        // Pass the combinational results straight out
        always_comb begin
            enc_code_o   = enc_code_c;
            dec_data_o   = dec_data_c;
            dec_single_o = single_c;
            dec_double_o = double_c;
        end
    end

endmodule

// File: tb/secded_codec_tb.sv
module secded_codec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  enc_data_i = '0;
    logic [12:0] enc_code_o;
    logic [12:0] dec_code_i = '0;
    logic [7:0]  dec_data_o;
    logic        dec_single_o;
    logic        dec_double_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    secded_codec dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enc_data_i   (enc_data_i),
        .enc_code_o   (enc_code_o),
        .dec_code_i   (dec_code_i),
        .dec_data_o   (dec_data_o),
        .dec_single_o (dec_single_o),
        .dec_double_o (dec_double_o)
    );

    // Behavioural encoder built from the requirement text
    function automatic logic [12:0] ref_encode(input logic [7:0] d);
        logic [12:0] c;
        int k;
        logic par;
        c = '0;
        k = 0;
        for (int p = 1; p <= 12; p++) begin
            if (p != 1 && p != 2 && p != 4 && p != 8) begin
                c[p-1] = d[k];
                k++;
            end
        end
        for (int i = 0; i < 4; i++) begin
            par = 1'b0;
            for (int p = 1; p <= 12; p++)
                if (((p >> i) & 1) == 1) par = par ^ c[p-1];
            c[(1 << i) - 1] = par;
        end
        par = 1'b0;
        for (int b = 0; b < 12; b++) par = par ^ c[b];
        c[12] = par;
        return c;
    endfunction

    function automatic logic [7:0] ref_extract(input logic [12:0] c);
        int slots [8] = '{3, 5, 6, 7, 9, 10, 11, 12};
        logic [7:0] d;
        for (int k = 0; k < 8; k++) d[k] = c[slots[k] - 1];
        return d;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    // Drive both paths at a falling edge, compare one cycle later
    task automatic run(input string req, input logic [7:0] ed, input logic [12:0] dc,
                       input logic [7:0] xd, input logic xs, input logic xdb);
        logic [12:0] xc;
        xc = ref_encode(ed);
        enc_data_i = ed;
        dec_code_i = dc;
        @(negedge clk);
        chk(req, "enc_code", 32'(enc_code_o), 32'(xc));
        chk(req, "dec_data", 32'(dec_data_o), 32'(xd));
        chk(req, "single", 32'(dec_single_o), 32'(xs));
        chk(req, "double", 32'(dec_double_o), 32'(xdb));
        chk("R10", "flags exclusive", 32'(dec_single_o & dec_double_o), 32'd0);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [12:0] c;
        logic [7:0] vals [6] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81, 8'h6E};

        // R9: reset clears all outputs
        enc_data_i = 8'hFF;
        dec_code_i = 13'h1FFF;
        repeat (3) @(negedge clk);
        chk("R9", "reset enc", 32'(enc_code_o), 32'd0);
        chk("R9", "reset data", 32'(dec_data_o), 32'd0);
        chk("R9", "reset flags", 32'({dec_single_o, dec_double_o}), 32'd0);
        rst_n = 1'b1;

        // R1 R2 R3 R4: every byte encodes and round-trips clean
        for (int d = 0; d < 256; d++) begin
            c = ref_encode(8'(d));
            run("R4", 8'(d), c, 8'(d), 1'b0, 1'b0);
        end
        // R1: fixed layout spot check, data 0x01 -> positions 1,2,3 and parity
        run("R1", 8'h01, ref_encode(8'h01), 8'h01, 1'b0, 1'b0);
        chk("R1", "layout 0x01", 32'(enc_code_o), 32'h0007 | 32'h1000);

        // R5: each single flip in positions 1..12 is repaired
        foreach (vals[v]) begin
            for (int b = 0; b < 12; b++) begin
                c = ref_encode(vals[v]) ^ (13'd1 << b);
                run("R5", vals[v], c, vals[v], 1'b1, 1'b0);
            end
            // R6: flip of the overall bit only
            c = ref_encode(vals[v]) ^ 13'h1000;
            run("R6", vals[v], c, vals[v], 1'b1, 1'b0);
        end

        // R7: every pair of flips is reported, data left as received
        for (int v = 0; v < 4; v++) begin
            for (int a = 0; a < 13; a++) begin
                for (int b = a + 1; b < 13; b++) begin
                    c = ref_encode(vals[v]) ^ (13'd1 << a) ^ (13'd1 << b);
                    run("R7", vals[v], c, ref_extract(c), 1'b0, 1'b1);
                end
            end
        end

        // R8: triple flips whose syndrome is 13, 14, 15 (positions 1/2/3 with 4 and 8)
        foreach (vals[v]) begin
            for (int s = 0; s < 3; s++) begin
                c = ref_encode(vals[v]) ^ (13'd1 << s) ^ 13'h0008 ^ 13'h0080;
                run("R8", vals[v], c, ref_extract(c), 1'b0, 1'b1);
            end
        end

        // R9: outputs hold until the next rising edge
        run("R9", 8'h12, ref_encode(8'h12), 8'h12, 1'b0, 1'b0);
        enc_data_i = 8'h34;
        dec_code_i = ref_encode(8'h34);
        #2;
        chk("R9", "hold before edge", 32'(dec_data_o), 32'h12);
        chk("R9", "hold enc before edge", 32'(enc_code_o), 32'(ref_encode(8'h12)));
        @(negedge clk);
        chk("R9", "update after edge", 32'(dec_data_o), 32'h34);

        // R9: reset in mid-run clears outputs again
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9", "mid reset data", 32'(dec_data_o), 32'd0);
        chk("R9", "mid reset enc", 32'(enc_code_o), 32'd0);
        rst_n = 1'b1;
        run("R4", 8'hC3, ref_encode(8'hC3), 8'hC3, 1'b0, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule